// File: doc/BRIEF.md
# Victim Buffer for a Direct-Mapped Cache

This block is a small fully associative store that sits on the refill path of a direct-mapped cache. It keeps blocks that the main cache recently threw out. When the main cache misses, its controller presents the missing block address to the buffer. The buffer compares that address against every entry at the same time and answers within the same cycle.

On a hit, the buffer's block goes back to the main cache. At the next clock edge the buffer takes, in the same entry, the block that the main cache is pushing out to make room. The two blocks therefore trade places, and a conflict miss is resolved without a memory access. On a miss, the pushed-out block is stored, and the refill proceeds from memory.

Each entry holds the full block address, because there is no index to drop, together with a valid bit and one block of data. An empty entry is used first. When every entry is full, a round-robin pointer picks the entry to overwrite. A flush input empties the whole buffer.

Top module: `victim_buffer`

## Requirements
- R1: After reset every entry is empty, so no lookup reports a hit and the replacement pointer is at entry 0.
- R2: While `lkValid` is high, `lkHit` is asserted in the same cycle exactly when a valid entry holds an address equal to `lkAddr`. In that case `lkHitIdx` gives that entry's index and `lkHitData` its data. `lkHit` is low whenever `lkValid` is low.
- R3: When the lookup does not hit (or no lookup is made) and `evValid` is high, the block on `evAddr`/`evData` is written at the next edge into the lowest-numbered empty entry, if one exists.
- R4: When no entry is empty, such an insertion overwrites the entry named by the pointer, and the pointer advances by one modulo the entry count. Insertions into empty entries leave the pointer unchanged.
- R5: On a hit with `evValid` high, at the next edge the entry that hit takes the address and data on `evAddr`/`evData`. All other entries keep their contents and the pointer does not move.
- R6: On a hit with `evValid` low, the entry that hit becomes empty at the next edge, and no other entry changes.
- R7: `flushAll` empties every entry at the next edge and overrides a write requested in the same cycle.
- R8: With `lkValid` low, `evValid` alone performs the insertion of R3/R4. With both `lkValid` and `evValid` low, or on a miss with `evValid` low, no entry and no pointer change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| flushAll | input | 1 | Empty every entry |
| lkValid | input | 1 | Lookup request after a main-cache miss |
| lkAddr | input | ADDR_W | Block address searched for |
| lkHit | output | 1 | Lookup found the block |
| lkHitIdx | output | IDX_W | Index of the matching entry |
| lkHitData | output | DATA_W | Block data of the matching entry |
| evValid | input | 1 | A displaced main-cache block is offered |
| evAddr | input | ADDR_W | Block address of the displaced block |
| evData | input | DATA_W | Data of the displaced block |

## Verification
The hardest state to reach is a full buffer in which the pointer sits at some entry other than 0, while an entry in the middle has just been emptied by a hit without a displaced block. That is the state in which fill-first and round-robin choices disagree. The stimulus fills the buffer and then overflows it by several blocks to walk the pointer. It then takes a block out with a swap-free hit and inserts again, checking that the hole is refilled and the pointer is left alone. A long pseudo-random phase over a narrow address range then mixes swaps, takes, inserts and flushes. After every step, every address of the small configuration is probed within one clock-low phase.

// File: rtl/vb_pkg.sv
package vb_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic flush;    // clear all valid bits
    logic wrEn;     // write one entry
    logic wrValid;  // valid value written (0 = take the entry out)
  } vbStrobe_t;
endpackage

// File: rtl/vb_datapath.sv
module vb_datapath
  import vb_pkg::*;
#(
  parameter int ENTRIES = 4,
  parameter int ADDR_W  = 27,
  parameter int DATA_W  = 256,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  vbStrobe_t         strobe,
  input  logic [ENTRIES-1:0] wrSel,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] lkAddr,
  input  logic [IDX_W-1:0]  rdIdx,
  output logic [ENTRIES-1:0] matchVec,
  output logic [ENTRIES-1:0] validVec,
  output logic [DATA_W-1:0] rdData
);
  logic [ADDR_W-1:0] tagArr  [ENTRIES];
  logic [DATA_W-1:0] dataArr [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : gEntry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        validVec[g] <= 1'b0;
      else if (strobe.flush)
        validVec[g] <= 1'b0;
      else if (strobe.wrEn && wrSel[g])
        validVec[g] <= strobe.wrValid;
    end

    always_ff @(posedge clk) begin
      if (!strobe.flush && strobe.wrEn && wrSel[g] && strobe.wrValid) begin
        tagArr[g]  <= wrAddr;
        dataArr[g] <= wrData;
      end
    end

    assign matchVec[g] = validVec[g] && (tagArr[g] == lkAddr);
  end

  always_comb begin
    rdData = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (rdIdx == IDX_W'(i)) rdData = dataArr[i];
  end
endmodule

// File: rtl/vb_ctrl.sv
module vb_ctrl
  import vb_pkg::*;
#(
  parameter int ENTRIES = 4,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flushAll,
  input  logic              lkValid,
  input  logic              evValid,
  input  logic [ENTRIES-1:0] matchVec,
  input  logic [ENTRIES-1:0] validVec,
  output logic              hit,
  output logic [IDX_W-1:0]  hitIdx,
  output vbStrobe_t         strobe,
  output logic [ENTRIES-1:0] wrSel
);
  logic [IDX_W-1:0] rrPtr;
  logic [IDX_W-1:0] freeIdx;
  logic [IDX_W-1:0] wrIdx;
  logic             anyFree;
  logic             doReplace;

  always_comb begin
    hitIdx  = '0;
    freeIdx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (matchVec[i])  hitIdx  = IDX_W'(i);
      if (!validVec[i]) freeIdx = IDX_W'(i);
    end
  end

  assign hit       = lkValid && (|matchVec);
  assign anyFree   = ~(&validVec);
  assign doReplace = !hit && evValid && !anyFree;

  always_comb begin
    strobe.flush   = flushAll;
    strobe.wrEn    = hit || evValid;
    strobe.wrValid = hit ? evValid : 1'b1;
    if (hit)          wrIdx = hitIdx;
    else if (anyFree) wrIdx = freeIdx;
    else              wrIdx = rrPtr;
    wrSel = {{(ENTRIES-1){1'b0}}, 1'b1} << wrIdx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rrPtr <= '0;
    else if (!flushAll && doReplace)
      rrPtr <= (rrPtr == IDX_W'(ENTRIES - 1)) ? '0 : rrPtr + 1'b1;
  end
endmodule

// File: rtl/victim_buffer.sv
module victim_buffer
  import vb_pkg::*;
#(
  parameter int ENTRIES = 4,
  parameter int ADDR_W  = 27,
  parameter int DATA_W  = 256,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flushAll,
  input  logic              lkValid,
  input  logic [ADDR_W-1:0] lkAddr,
  output logic              lkHit,
  output logic [IDX_W-1:0]  lkHitIdx,
  output logic [DATA_W-1:0] lkHitData,
  input  logic              evValid,
  input  logic [ADDR_W-1:0] evAddr,
  input  logic [DATA_W-1:0] evData
);
  vbStrobe_t          strobe;
  logic [ENTRIES-1:0] wrSel;
  logic [ENTRIES-1:0] matchVec;
  logic [ENTRIES-1:0] validVec;

  vb_ctrl #(.ENTRIES(ENTRIES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .flushAll(flushAll),
    .lkValid(lkValid), .evValid(evValid),
    .matchVec(matchVec), .validVec(validVec),
    .hit(lkHit), .hitIdx(lkHitIdx), .strobe(strobe), .wrSel(wrSel)
  );

  vb_datapath #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .wrSel(wrSel),
    .wrAddr(evAddr), .wrData(evData), .lkAddr(lkAddr), .rdIdx(lkHitIdx),
    .matchVec(matchVec), .validVec(validVec), .rdData(lkHitData)
  );
endmodule

// File: rtl/vb_checker.sv
module vb_checker #(
  parameter int ENTRIES = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              flushAll,
  input logic              lkValid,
  input logic              lkHit,
  input logic              evValid,
  input logic [ENTRIES-1:0] validVec
);
  a_r2_hit_needs_lookup: assert property (@(posedge clk) disable iff (!rst_n)
    lkHit |-> lkValid);

  a_r7_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flushAll |=> !lkHit);

  a_r6_take_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
    (lkHit && !evValid && !flushAll) |=>
      ($countones(validVec) == $countones($past(validVec)) - 1));

  a_r5_swap_keeps_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (lkHit && evValid && !flushAll) |=> $stable(validVec));

  a_r3_fill_grows: assert property (@(posedge clk) disable iff (!rst_n)
    (!lkHit && evValid && !flushAll && !(&validVec)) |=>
      ($countones(validVec) == $countones($past(validVec)) + 1));

  a_r8_idle_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (!lkHit && !evValid && !flushAll) |=> $stable(validVec));
endmodule

bind victim_buffer vb_checker #(.ENTRIES(ENTRIES)) u_chk (
  .clk(clk), .rst_n(rst_n), .flushAll(flushAll), .lkValid(lkValid),
  .lkHit(lkHit), .evValid(evValid), .validVec(validVec)
);

// File: tb/victim_buffer_tb.sv
`timescale 1ns/1ps
module victim_buffer_tb;
  localparam int ENTRIES = 4;
  localparam int ADDR_W  = 8;
  localparam int DATA_W  = 16;
  localparam int IDX_W   = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flushAll = 1'b0, lkValid = 1'b0, evValid = 1'b0;
  logic [ADDR_W-1:0] lkAddr = '0, evAddr = '0;
  logic [DATA_W-1:0] evData = '0;
  logic              lkHit;
  logic [IDX_W-1:0]  lkHitIdx;
  logic [DATA_W-1:0] lkHitData;

  always #4 clk = ~clk;

  victim_buffer #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .flushAll(flushAll),
    .lkValid(lkValid), .lkAddr(lkAddr), .lkHit(lkHit), .lkHitIdx(lkHitIdx),
    .lkHitData(lkHitData), .evValid(evValid), .evAddr(evAddr), .evData(evData)
  );

  int checks = 0, errors = 0;
  logic              mValid [ENTRIES];
  logic [ADDR_W-1:0] mAddr  [ENTRIES];
  logic [DATA_W-1:0] mData  [ENTRIES];
  int                mPtr;
  logic [15:0]       lfsr = 16'hACE1;

  function automatic logic [DATA_W-1:0] payload(input logic [ADDR_W-1:0] a, input int salt);
    return {a, a ^ 8'(salt * 37)};
  endfunction

  task automatic expect_of(input logic [ADDR_W-1:0] a, output logic h, output int idx);
    h = 1'b0; idx = 0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (mValid[i] && mAddr[i] == a) begin h = 1'b1; idx = i; end
  endtask

  task automatic chk(input string req, input logic [ADDR_W-1:0] a);
    logic h; int idx;
    expect_of(a, h, idx);
    checks++;
    if (lkHit !== h || (h && (lkHitIdx !== IDX_W'(idx) || lkHitData !== mData[idx]))) begin
      errors++;
      $display("FAIL %s addr=%0h actual hit=%b idx=%0d data=%h expected hit=%b idx=%0d data=%h",
               req, a, lkHit, lkHitIdx, lkHitData, h, idx, h ? mData[idx] : '0);
    end
  endtask

  // probe every address in one clock-low phase; no edge passes
  task automatic sweep(input string req);
    @(negedge clk);
    lkValid = 1'b1;
    for (int a = 0; a < (1 << ADDR_W); a++) begin
      lkAddr = ADDR_W'(a);
      #0.01;
      chk(req, ADDR_W'(a));
    end
    lkValid = 1'b0;
    checks++;
    #0.01;
    if (lkHit !== 1'b0) begin
      errors++;
      $display("FAIL R2 hit without lookup actual=%b expected=0", lkHit);
    end
  endtask

  // one clocked operation, checked and then applied to the model
  task automatic step(input string req, input logic lk, input logic [ADDR_W-1:0] la,
                      input logic ev, input logic [ADDR_W-1:0] ea, input int salt,
                      input logic fl);
    logic h; int idx; logic freeFound; int freeIdx;
    @(negedge clk);
    lkValid = lk; lkAddr = la; evValid = ev; evAddr = ea;
    evData = payload(ea, salt); flushAll = fl;
    #1;
    if (lk) chk(req, la);
    expect_of(la, h, idx);
    h = h && lk;
    @(posedge clk);
    if (fl) begin
      for (int i = 0; i < ENTRIES; i++) mValid[i] = 1'b0;
    end else if (h) begin
      if (ev) begin mAddr[idx] = ea; mData[idx] = payload(ea, salt); end
      else mValid[idx] = 1'b0;
    end else if (ev) begin
      freeFound = 1'b0; freeIdx = 0;
      for (int i = ENTRIES - 1; i >= 0; i--)
        if (!mValid[i]) begin freeFound = 1'b1; freeIdx = i; end
      if (!freeFound) begin freeIdx = mPtr; mPtr = (mPtr + 1) % ENTRIES; end
      mValid[freeIdx] = 1'b1; mAddr[freeIdx] = ea; mData[freeIdx] = payload(ea, salt);
    end
    #1;
    lkValid = 1'b0; evValid = 1'b0; flushAll = 1'b0;
  endtask

  initial begin
    #1200000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < ENTRIES; i++) begin mValid[i] = 1'b0; mAddr[i] = '0; mData[i] = '0; end
    mPtr = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    sweep("R1 reset empty");

    // R8/R3: inserts without lookup fill entries 0..3
    for (int k = 0; k < 4; k++) step("R8 insert", 1'b0, '0, 1'b1, ADDR_W'(8'h10 + k), k, 1'b0);
    sweep("R2 after fill");

    // R4: overflow by five walks the pointer 0,1,2,3,0 -> ends at 1
    for (int k = 0; k < 5; k++) step("R4 replace", 1'b0, '0, 1'b1, ADDR_W'(8'h40 + k), k + 9, 1'b0);
    sweep("R4 round robin");

    // R5: swap entry holding 0x41 with displaced 0x77
    step("R5 swap lookup", 1'b1, 8'h41, 1'b1, 8'h77, 3, 1'b0);
    sweep("R5 after swap");

    // R6: take 0x42 out without a displaced block, then R3 refill of the hole
    step("R6 take", 1'b1, 8'h42, 1'b0, '0, 0, 1'b0);
    sweep("R6 after take");
    step("R3 miss fills hole", 1'b1, 8'h99, 1'b1, 8'h99, 5, 1'b0);
    sweep("R3 hole refilled");

    // R4: pointer untouched by hole fill
    step("R4 replace after fill", 1'b1, 8'hA0, 1'b1, 8'hA0, 6, 1'b0);
    sweep("R4 pointer kept");

    // R8: misses and idle without displaced block change nothing
    step("R8 miss no insert", 1'b1, 8'hEE, 1'b0, 8'hEE, 7, 1'b0);
    step("R8 idle", 1'b0, 8'h00, 1'b0, 8'h00, 7, 1'b0);
    sweep("R8 unchanged");

    // R7: flush overrides a same-cycle swap
    step("R7 flush with swap", 1'b1, 8'hA0, 1'b1, 8'h55, 8, 1'b1);
    sweep("R7 flushed");

    // mixed pseudo-random traffic over a narrow range
    for (int n = 0; n < 1500; n++) begin
      logic [15:0] r;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      r = lfsr;
      step("R2 R5 R6 random", r[0] | r[1], {4'h0, r[5:2]}, r[6] | r[7],
           {4'h0, r[11:8]}, n, (r[15:12] == 4'hF));
      if (n % 100 == 99) sweep("R4 R5 random sweep");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule